// File: doc/BRIEF.md
# Streaming Itemset Support Counter

This block keeps a small table of candidate itemsets and measures how often each one occurs in a stream of transactions. Every itemset and every transaction has the same fixed width, one bit per item in the item universe. A candidate is contained in a transaction when ANDing the two gives the candidate back. The transaction is passed down a chain of processing elements, one for each table entry. Each element compares its entry with the transaction and bumps the entry's support on a match.

The block alternates between counting and replacement. Once a programmable number of transactions has been accepted, the block stops taking input, lets the chain drain, and runs a short replacement phase. In that phase, itemsets drawn from the most recent transactions, restricted to items that are frequent on their own, take the place of the weakest entries in Space-Saving fashion. Counting then resumes. A preload port fills the table before streaming starts. A combinational readout port lets any entry be inspected.

Top module: `itemset_miner`

## Requirements
- R1: After reset every entry reads back itemset 0 and support 0, and in_ready is 1.
- R2: A cycle with load_en high writes load_items and load_sup into entry load_idx. rd_items and rd_sup show entry rd_idx combinationally.
- R3: For every accepted transaction t, a nonzero entry with itemset c gains 1 support when (t & c) == c. Otherwise it is unchanged. An all-zero entry never gains support from counting.
- R4: Supports saturate at 2^CNT_W-1 (255 by default) and never wrap.
- R5: Once the accepted-transaction count reaches thr_trans, in_ready is 0 from the following cycle until replacement ends. Held input is not taken during that time. Every entry has finished counting before replacement starts.
- R6: Each item keeps a saturating count of the accepted transactions that contain it. An item is eligible when its count is >= thr_item.
- R7: Replacement step i (i = 0 for the most recent accepted transaction) proposes that transaction ANDed with the eligible-item mask. A step is skipped when the proposal is zero or equals an itemset already in the table.
- R8: A proposal replaces the entry with the smallest support, the lowest index winning ties. The new entry's support is that minimum plus 1, saturating.
- R9: One replacement phase performs min(thr_repl, HIST) steps (HIST = 4 by default). Skipped steps are counted.
- R10: When replacement ends, in_ready returns to 1 with the transaction count cleared, and the phases keep alternating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Transaction valid |
| in_ready | output | 1 | Transaction accepted when both are high |
| in_items | input | N_ITEMS | Transaction item bitvector |
| thr_trans | input | CNT_W | Transactions per counting phase |
| thr_item | input | CNT_W | Minimum item count for eligibility |
| thr_repl | input | CNT_W | Maximum replacement steps per phase |
| load_en | input | 1 | Preload write strobe |
| load_idx | input | IDX_W | Preload entry index |
| load_items | input | N_ITEMS | Preload itemset |
| load_sup | input | CNT_W | Preload support |
| rd_idx | input | IDX_W | Readout entry index |
| rd_items | output | N_ITEMS | Readout itemset |
| rd_sup | output | CNT_W | Readout support |

## Verification
Directed transactions cover five containment cases: an exact match, a strict superset, a disjoint set, a partial overlap, and a hit on an entry already near saturation. Each case tells a real subset test apart from a mere overlap test. A directed replacement phase feeds a recent transaction that repeats, so that a new entry becomes the next victim at once and a duplicate proposal must be skipped. Random streams of mixed item density, run with step limits of zero, one and more than the history depth, compare the whole table against a model built from the requirements. These runs separate a wrong victim choice, a wrong tie-break, a wrong eligibility mask or a wrong step limit.

// File: rtl/itemset_pkg.sv
package itemset_pkg;
    parameter int N_ITEMS = 8;
    parameter int CAND    = 4;
    parameter int CNT_W   = 8;
    parameter int HIST    = 4;

    localparam int IDX_W  = (CAND > 1) ? $clog2(CAND) : 1;
    localparam int STEP_W = $clog2(HIST + 1);

    typedef logic [N_ITEMS-1:0] items_t;
    typedef logic [CNT_W-1:0]   sup_t;

    typedef enum logic [1:0] {PH_COUNT, PH_DRAIN, PH_REPL} phase_e;

    typedef struct packed {
        logic   vld;
        items_t bits;
    } beat_t;

    function automatic sup_t sat_inc(input sup_t s);
        return (s == {CNT_W{1'b1}}) ? s : s + 1'b1;
    endfunction
endpackage

// File: rtl/itemset_pe.sv
module itemset_pe
    import itemset_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  beat_t  beat_in,
    output beat_t  beat_out,
    input  logic   wr_en,
    input  items_t wr_items,
    input  sup_t   wr_sup,
    output items_t items,
    output sup_t   sup
);
    logic hit;
    assign hit = beat_in.vld && (items != '0) && ((beat_in.bits & items) == items);

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_out <= '0;
            items    <= '0;
            sup      <= '0;
        end else begin
            beat_out <= beat_in;
            if (wr_en) begin
                items <= wr_items;
                sup   <= wr_sup;
            end else if (hit) begin
                sup <= sat_inc(sup);
            end
        end
    end
endmodule

// File: rtl/itemset_min_sel.sv
module itemset_min_sel
    import itemset_pkg::*;
(
    input  sup_t             sups [CAND],
    output logic [IDX_W-1:0] idx,
    output sup_t             minv
);
    always_comb begin
        minv = sups[0];
        idx  = '0;
        for (int k = 1; k < CAND; k++) begin
            if (sups[k] < minv) begin
                minv = sups[k];
                idx  = IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/itemset_item_cnt.sv
module itemset_item_cnt
    import itemset_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   accept,
    input  items_t txn,
    input  sup_t   thr_item,
    output items_t mask
);
    for (genvar i = 0; i < N_ITEMS; i++) begin : g_item
        sup_t cnt_q;
        always_ff @(posedge clk) begin
            if (rst)                  cnt_q <= '0;
            else if (accept && txn[i]) cnt_q <= sat_inc(cnt_q);
        end
        assign mask[i] = (cnt_q >= thr_item);
    end
endmodule

// File: rtl/itemset_miner.sv
module itemset_miner
    import itemset_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [N_ITEMS-1:0] in_items,
    input  logic [CNT_W-1:0] thr_trans,
    input  logic [CNT_W-1:0] thr_item,
    input  logic [CNT_W-1:0] thr_repl,
    input  logic             load_en,
    input  logic [IDX_W-1:0] load_idx,
    input  logic [N_ITEMS-1:0] load_items,
    input  logic [CNT_W-1:0] load_sup,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [N_ITEMS-1:0] rd_items,
    output logic [CNT_W-1:0] rd_sup
);
    phase_e            phase;
    sup_t              txn_cnt;
    logic [STEP_W-1:0] step;
    logic [STEP_W-1:0] limit;
    items_t            hist [HIST];
    items_t            hist_sel, cand_new, mask;
    items_t            items_a [CAND];
    sup_t              sup_a   [CAND];
    beat_t             chain   [CAND+1];
    logic [IDX_W-1:0]  victim;
    sup_t              min_sup;
    logic              accept, pipe_busy, dup, do_repl;
    logic [CNT_W:0]    cnt_nxt;

    assign in_ready = (phase == PH_COUNT);
    assign accept   = in_valid && in_ready;
    assign chain[0] = '{vld: accept, bits: in_items};
    assign cnt_nxt  = {1'b0, txn_cnt} + 1'b1;
    assign limit    = (thr_repl > CNT_W'(HIST)) ? STEP_W'(HIST) : thr_repl[STEP_W-1:0];

    for (genvar k = 0; k < CAND; k++) begin : g_pe
        logic   we;
        items_t wi;
        sup_t   ws;
        assign we = (load_en && load_idx == IDX_W'(k)) || (do_repl && victim == IDX_W'(k));
        assign wi = load_en ? load_items : cand_new;
        assign ws = load_en ? load_sup   : sat_inc(min_sup);
        itemset_pe u_pe (
            .clk(clk), .rst(rst),
            .beat_in(chain[k]), .beat_out(chain[k+1]),
            .wr_en(we), .wr_items(wi), .wr_sup(ws),
            .items(items_a[k]), .sup(sup_a[k])
        );
    end

    itemset_min_sel u_min (.sups(sup_a), .idx(victim), .minv(min_sup));

    itemset_item_cnt u_icnt (
        .clk(clk), .rst(rst), .accept(accept), .txn(in_items),
        .thr_item(thr_item), .mask(mask)
    );

    always_comb begin
        pipe_busy = 1'b0;
        for (int k = 1; k <= CAND; k++) pipe_busy = pipe_busy | chain[k].vld;
        hist_sel = '0;
        for (int i = 0; i < HIST; i++)
            if (step == STEP_W'(i)) hist_sel = hist[i];
        cand_new = hist_sel & mask;
        dup = 1'b0;
        for (int k = 0; k < CAND; k++)
            if (items_a[k] == cand_new) dup = 1'b1;
        do_repl = (phase == PH_REPL) && (step < limit) && (cand_new != '0) && !dup;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HIST; i++) hist[i] <= '0;
        end else if (accept) begin
            hist[0] <= in_items;
            for (int i = 1; i < HIST; i++) hist[i] <= hist[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_COUNT;
            txn_cnt <= '0;
            step    <= '0;
        end else begin
            unique case (phase)
                PH_COUNT: if (accept) begin
                    txn_cnt <= cnt_nxt[CNT_W-1:0];
                    if (cnt_nxt >= {1'b0, thr_trans}) phase <= PH_DRAIN;
                end
                PH_DRAIN: if (!pipe_busy) begin
                    phase <= PH_REPL;
                    step  <= '0;
                end
                PH_REPL: begin
                    if (step >= limit) begin
                        phase   <= PH_COUNT;
                        txn_cnt <= '0;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                default: phase <= PH_COUNT;
            endcase
        end
    end

    assign rd_items = items_a[rd_idx];
    assign rd_sup   = sup_a[rd_idx];
endmodule

// File: rtl/itemset_miner_chk.sv
module itemset_miner_chk
    import itemset_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input phase_e            phase,
    input logic              pipe_busy,
    input sup_t              txn_cnt,
    input logic [STEP_W-1:0] step,
    input sup_t              sup0,
    input logic              load_en
);
    // R5: input is only closed off right after a transaction was taken
    p_close_after_accept_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(in_ready) |-> $past(in_valid));

    // R5: replacement never overlaps in-flight counting
    p_drained_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_REPL) |-> !pipe_busy);

    // R4: counting never lowers a support (saturation, no wrap)
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_COUNT && !load_en) |=> (sup0 >= $past(sup0)));

    // R9: step counter stays within the history depth
    p_step_bound_r9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_REPL) |-> (step <= STEP_W'(HIST)));

    // R10: counting resumes with a cleared transaction count
    p_resume_clear_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(in_ready) |-> (txn_cnt == '0));
endmodule

bind itemset_miner itemset_miner_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .phase(phase), .pipe_busy(pipe_busy), .txn_cnt(txn_cnt), .step(step),
    .sup0(sup_a[0]), .load_en(load_en)
);

// File: tb/itemset_miner_tb.sv
`timescale 1ns/1ps
module itemset_miner_tb;
    import itemset_pkg::*;

    localparam int SMAX = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_ready;
    logic [N_ITEMS-1:0] in_items = '0;
    logic [CNT_W-1:0] thr_trans = 200, thr_item = 2, thr_repl = 2;
    logic load_en = 1'b0;
    logic [IDX_W-1:0] load_idx = '0, rd_idx = '0;
    logic [N_ITEMS-1:0] load_items = '0, rd_items;
    logic [CNT_W-1:0] load_sup = '0, rd_sup;

    int n_chk = 0, n_bad = 0;

    int m_items [CAND];
    int m_sup   [CAND];
    int m_isup  [N_ITEMS];
    int m_hist  [HIST];
    int m_cnt = 0;

    always #4 clk = ~clk;

    itemset_miner u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_items(in_items), .thr_trans(thr_trans), .thr_item(thr_item),
        .thr_repl(thr_repl), .load_en(load_en), .load_idx(load_idx),
        .load_items(load_items), .load_sup(load_sup), .rd_idx(rd_idx),
        .rd_items(rd_items), .rd_sup(rd_sup)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > SMAX) ? SMAX : v;
    endfunction

    // R7 R8 R9: model of one replacement phase
    function automatic void model_repl();
        int mask = 0;
        int lim = (int'(thr_repl) > HIST) ? HIST : int'(thr_repl);
        for (int i = 0; i < N_ITEMS; i++)
            if (m_isup[i] >= int'(thr_item)) mask |= (1 << i);
        for (int s = 0; s < lim; s++) begin
            int c = m_hist[s] & mask;
            bit d = 0;
            int v = 0;
            for (int k = 0; k < CAND; k++) if (m_items[k] == c) d = 1;
            if (c != 0 && !d) begin
                for (int k = 1; k < CAND; k++) if (m_sup[k] < m_sup[v]) v = k;
                m_items[v] = c;
                m_sup[v] = sat(m_sup[v] + 1);
            end
        end
    endfunction

    // R3 R4 R6 R10: model of one accepted transaction
    function automatic void model_accept(input int t);
        for (int k = 0; k < CAND; k++)
            if (m_items[k] != 0 && (t & m_items[k]) == m_items[k]) m_sup[k] = sat(m_sup[k] + 1);
        for (int i = 0; i < N_ITEMS; i++) if (t[i]) m_isup[i] = sat(m_isup[i] + 1);
        for (int i = HIST - 1; i > 0; i--) m_hist[i] = m_hist[i-1];
        m_hist[0] = t;
        m_cnt++;
        if (m_cnt >= int'(thr_trans)) begin
            model_repl();
            m_cnt = 0;
        end
    endfunction

    task automatic send(input int t);
        logic r;
        @(negedge clk);
        in_valid = 1'b1;
        in_items = N_ITEMS'(t);
        forever begin
            r = in_ready;
            @(posedge clk);
            if (r) break;
            @(negedge clk);
        end
        model_accept(t);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic load(input int idx, input int it, input int s);
        @(negedge clk);
        load_en = 1'b1; load_idx = IDX_W'(idx);
        load_items = N_ITEMS'(it); load_sup = CNT_W'(s);
        @(negedge clk);
        load_en = 1'b0;
        m_items[idx] = it; m_sup[idx] = s;
    endtask

    task automatic settle();
        repeat (CAND + HIST + 6) @(negedge clk);
    endtask

    task automatic check_table(input string tag);
        for (int k = 0; k < CAND; k++) begin
            rd_idx = IDX_W'(k);
            #1;
            check($sformatf("%s entry %0d itemset", tag, k), int'(rd_items), m_items[k]);
            check($sformatf("%s entry %0d support", tag, k), int'(rd_sup), m_sup[k]);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int k = 0; k < CAND; k++) begin m_items[k] = 0; m_sup[k] = 0; end
        for (int i = 0; i < N_ITEMS; i++) m_isup[i] = 0;
        for (int i = 0; i < HIST; i++) m_hist[i] = 0;
        void'($urandom(32'd4711));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready after reset", int'(in_ready), 1);
        check_table("R1 reset");

        load(0, 'h03, 0);
        load(1, 'h06, 5);
        load(2, 'h80, SMAX - 1);
        check_table("R2 preload");

        // R3: exact, superset, partial hit, disjoint; R4: saturation
        send('h03); send('h07); send('h81); send('h80); send('h04);
        settle();
        check_table("R3 containment");
        rd_idx = IDX_W'(2); #1;
        check("R4 saturated support", int'(rd_sup), SMAX);
        rd_idx = IDX_W'(3); #1;
        check("R3 empty entry stays zero", int'(rd_sup), 0);

        // R5-R9: directed replacement with a duplicate proposal
        thr_trans = 8; thr_item = 3; thr_repl = 3;
        send('h0F); send('h0F);
        send('h31);
        check("R5 ready low after threshold", int'(in_ready), 0);
        settle();
        check("R10 ready restored", int'(in_ready), 1);
        check_table("R7 R8 directed replacement");
        rd_idx = IDX_W'(3); #1;
        check("R8 victim reused itemset", int'(rd_items), 'h07);
        check("R8 victim support", int'(rd_sup), 2);

        // R9 R10 R6: random streams with different step limits
        thr_trans = 7;
        for (int b = 0; b < 4; b++) begin
            thr_repl = (b == 0) ? 0 : (b == 1) ? 1 : (b == 2) ? 6 : 2;
            thr_item = (b == 3) ? 0 : 3;
            for (int n = 0; n < 40; n++) begin
                int t = int'($urandom) & ((1 << N_ITEMS) - 1);
                if (n % 3 == 0) t &= int'($urandom);
                send(t);
            end
            settle();
            check_table($sformatf("R9 R6 random block %0d", b));
        end

        // R5: held input while busy is not taken early
        thr_trans = 1; thr_repl = 2;
        send('h0F);
        in_valid = 1'b1; in_items = 'h55;
        @(negedge clk);
        check("R5 held input refused", int'(in_ready), 0);
        in_valid = 1'b0;
        settle();
        check_table("R5 R10 after short phase");

        finish_run();
    end
endmodule